// File: doc/BRIEF.md
# Two-Share Masked Prefix Adder

This unit adds two k-bit words modulo 2^k while every operand and the result stay split into two Boolean shares. No step ever XORs the two shares of a value together. Each operand arrives as a pair of words whose XOR is the real value. The sum leaves the same way: `z0 ^ z1` equals `(x + y) mod 2^k`.

Internally it builds a generate/propagate carry prefix, one doubling of the prefix span per clock. A single combinational datapath computes a masked AND of a word with a left-shifted word, and a second one computes the same product XORed back into its shifted operand. The initial masked AND needs one guard bit, which is the single fresh random input bit. Every later guarded step reuses the least significant bit of an existing share as its guard. When the sum is ready, the guard bit the unit holds at that point goes back out, so the next addition can use it as its fresh bit.

The caller places the four operand shares and the random bit on the inputs and pulses `start` while the unit is idle. The unit registers the operands on that edge, so the inputs may change afterwards. The number of prefix levels is L = max(ceil(log2(k-1)), 1). This gives L = 5 for k = 32 and L = 3 for k = 8.

Top module: `mk_adder`

## Requirements
- R1: During and directly after synchronous reset, `done` is 0 and `z0`, `z1` and `rnd_out` are all zero.
- R2: When `done` is 1, `z0 ^ z1` equals `((x0 ^ x1) + (y0 ^ y1)) mod 2^k`, using the operand shares that were registered with the accepted `start`. This holds for any split of the operands into shares and for either value of `rnd_in`.
- R3: `done` is a one-cycle pulse. Count the clock edge that samples an accepted `start` as edge 1. `done` is then visible right after edge L+2: edge 7 for k = 32 and edge 5 for k = 8.
- R4: `start` is accepted only while the unit is idle. A `start` seen while an addition is running or while `done` is high has no effect: no extra `done` pulse follows, and the running addition completes with its own operands and its own timing.
- R5: `z0`, `z1` and `rnd_out` change only on the edge that raises `done`. Between results they hold their values, whatever the data inputs do.
- R6: `rnd_out` returns the guard bit after the last prefix level. For k = 8 this bit equals bit 1 of `x0 ^ y0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an addition; accepted only while idle |
| x0 | input | WIDTH | First share of operand x |
| x1 | input | WIDTH | Second share of operand x |
| y0 | input | WIDTH | First share of operand y |
| y1 | input | WIDTH | Second share of operand y |
| rnd_in | input | 1 | Fresh random guard bit for this addition |
| z0 | output | WIDTH | First share of the sum |
| z1 | output | WIDTH | Second share of the sum |
| rnd_out | output | 1 | Guard bit handed on for a following addition |
| done | output | 1 | One-cycle pulse marking a valid result |

## Verification
Fixed vectors cover the cases that expose a wrong prefix span or a misplaced shift:
- all-ones plus one and all-ones plus all-ones, where a carry runs through every bit;
- MSB-only operands, whose carry is dropped;
- alternating bit patterns that sum to all-ones plus one;
- a mixed value.

Random operands with random share splits on both a 32-bit and an 8-bit instance separate a correct level count from an off-by-one count, because the two widths need different numbers of levels. Directed sequences do the rest:
- a second `start` during a run and another during the `done` cycle, to show both are ignored;
- changing the data inputs after a result, to show the outputs hold;
- comparing the returned guard bit on the 8-bit instance against the share bit it must come from.

// File: rtl/mk_adder_pkg.sv
package mk_adder_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INIT,
        ST_LEVEL,
        ST_FINAL,
        ST_DONE
    } mk_state_e;

    // Control strobes produced by the sequencer for the datapath.
    typedef struct packed {
        logic load_ops;   // register operand shares and fresh bit
        logic do_init;    // form first generate/propagate shares
        logic do_level;   // one intermediate prefix level
        logic do_final;   // last generate update and output forming
    } mk_ctl_t;

    // Prefix level count: max(ceil(log2(k-1)), 1)
    function automatic int level_count(input int k);
        int c;
        c = 0;
        while ((1 << c) < (k - 1)) c = c + 1;
        if (c < 1) c = 1;
        return c;
    endfunction

endpackage

// File: rtl/mk_guard_and.sv
// Masked AND of share pair a with share pair b shifted left by shamt,
// remasked with a guard word built from a0 and one guard bit.
module mk_guard_and #(
    parameter int WIDTH = 32,
    parameter int SW    = 6
) (
    input  logic [WIDTH-1:0] a0,
    input  logic [WIDTH-1:0] a1,
    input  logic [WIDTH-1:0] b0,
    input  logic [WIDTH-1:0] b1,
    input  logic [SW-1:0]    shamt,
    input  logic             guard,
    output logic [WIDTH-1:0] z0,
    output logic [WIDTH-1:0] z1
);
    logic [WIDTH-1:0] bs0, bs1, gmask;
    logic [WIDTH-1:0] t0, t1;

    always_comb begin
        bs0   = b0 << shamt;
        bs1   = b1 << shamt;
        gmask = (a0 >> 1) ^ {guard, {(WIDTH-1){1'b0}}};
        // apply guard before mixing in the cross-share products
        t0    = (a0 & bs0) ^ gmask;
        t1    = (a0 & bs1) ^ gmask;
        z0    = t0 ^ (a1 & bs0);
        z1    = t1 ^ (a1 & bs1);
    end
endmodule

// File: rtl/mk_and_xor.sv
// Masked (a AND (b << shamt)) XOR b; the b shares serve as their own guard.
module mk_and_xor #(
    parameter int WIDTH = 32,
    parameter int SW    = 6
) (
    input  logic [WIDTH-1:0] a0,
    input  logic [WIDTH-1:0] a1,
    input  logic [WIDTH-1:0] b0,
    input  logic [WIDTH-1:0] b1,
    input  logic [SW-1:0]    shamt,
    output logic [WIDTH-1:0] z0,
    output logic [WIDTH-1:0] z1
);
    logic [WIDTH-1:0] bs0, bs1, t0, t1;

    always_comb begin
        bs0 = b0 << shamt;
        bs1 = b1 << shamt;
        t0  = (a0 & bs0) ^ b0;
        t1  = (a0 & bs1) ^ b1;
        z0  = t0 ^ (a1 & bs0);
        z1  = t1 ^ (a1 & bs1);
    end
endmodule

// File: rtl/mk_ctrl.sv
// Sequencer: idle -> init -> levels -> final -> done.
module mk_ctrl
    import mk_adder_pkg::*;
#(
    parameter int NLEV = 5,
    parameter int LW   = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    output mk_state_e       state,
    output logic [LW-1:0]   lvl,
    output mk_ctl_t         ctl
);
    mk_state_e state_q, state_d;
    logic [LW-1:0] lvl_q, lvl_d;

    always_comb begin
        state_d = state_q;
        lvl_d   = lvl_q;
        ctl     = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    ctl.load_ops = 1'b1;
                    state_d      = ST_INIT;
                end
            end
            ST_INIT: begin
                ctl.do_init = 1'b1;
                lvl_d       = LW'(1);
                state_d     = (NLEV == 1) ? ST_FINAL : ST_LEVEL;
            end
            ST_LEVEL: begin
                ctl.do_level = 1'b1;
                lvl_d        = lvl_q + LW'(1);
                if (lvl_q == LW'(NLEV - 1)) state_d = ST_FINAL;
            end
            ST_FINAL: begin
                ctl.do_final = 1'b1;
                state_d      = ST_DONE;
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            lvl_q   <= '0;
        end else begin
            state_q <= state_d;
            lvl_q   <= lvl_d;
        end
    end

    assign state = state_q;
    assign lvl   = lvl_q;
endmodule

// File: rtl/mk_adder.sv
module mk_adder
    import mk_adder_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WIDTH-1:0] x0,
    input  logic [WIDTH-1:0] x1,
    input  logic [WIDTH-1:0] y0,
    input  logic [WIDTH-1:0] y1,
    input  logic             rnd_in,
    output logic [WIDTH-1:0] z0,
    output logic [WIDTH-1:0] z1,
    output logic             rnd_out,
    output logic             done
);
    localparam int NLEV = level_count(WIDTH);
    localparam int LW   = $clog2(NLEV + 1);
    localparam int SW   = $clog2(WIDTH) + 1;

    typedef struct packed {
        logic [WIDTH-1:0] s0;
        logic [WIDTH-1:0] s1;
    } pair_t;

    mk_state_e      state;
    logic [LW-1:0]  lvl;
    mk_ctl_t        ctl;

    pair_t xr, yr, g_q, p_q;
    pair_t ga_a, ga_b, ga_z, ax_z;
    logic  [SW-1:0] shamt, ga_sh;
    logic  u_q;
    pair_t z_q;
    logic  rnd_q;

    mk_ctrl #(.NLEV(NLEV), .LW(LW)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .state (state),
        .lvl   (lvl),
        .ctl   (ctl)
    );

    // prefix span for the current level: 2^(lvl-1)
    always_comb begin
        if (lvl == '0) shamt = '0;
        else           shamt = SW'(1) << (lvl - LW'(1));
    end

    // the guarded unit serves the initial AND (x, y, no shift)
    // and every propagate update (p, p, level shift)
    always_comb begin
        if (state == ST_INIT) begin
            ga_a  = xr;
            ga_b  = yr;
            ga_sh = '0;
        end else begin
            ga_a  = p_q;
            ga_b  = p_q;
            ga_sh = shamt;
        end
    end

    mk_guard_and #(.WIDTH(WIDTH), .SW(SW)) u_gand (
        .a0    (ga_a.s0),
        .a1    (ga_a.s1),
        .b0    (ga_b.s0),
        .b1    (ga_b.s1),
        .shamt (ga_sh),
        .guard (u_q),
        .z0    (ga_z.s0),
        .z1    (ga_z.s1)
    );

    mk_and_xor #(.WIDTH(WIDTH), .SW(SW)) u_gxor (
        .a0    (p_q.s0),
        .a1    (p_q.s1),
        .b0    (g_q.s0),
        .b1    (g_q.s1),
        .shamt (shamt),
        .z0    (ax_z.s0),
        .z1    (ax_z.s1)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            xr    <= '0;
            yr    <= '0;
            g_q   <= '0;
            p_q   <= '0;
            u_q   <= 1'b0;
            z_q   <= '0;
            rnd_q <= 1'b0;
        end else begin
            if (ctl.load_ops) begin
                xr  <= '{s0: x0, s1: x1};
                yr  <= '{s0: y0, s1: y1};
                u_q <= rnd_in;
            end
            if (ctl.do_init) begin
                g_q   <= ga_z;
                p_q   <= '{s0: xr.s0 ^ yr.s0, s1: xr.s1 ^ yr.s1};
                u_q   <= xr.s0[0];
            end
            if (ctl.do_level) begin
                // generate uses the propagate shares from before this level
                g_q <= ax_z;
                p_q <= ga_z;
                u_q <= p_q.s0[0];
            end
            if (ctl.do_final) begin
                g_q      <= ax_z;
                z_q.s0   <= xr.s0 ^ yr.s0 ^ (ax_z.s0 << 1);
                z_q.s1   <= xr.s1 ^ yr.s1 ^ (ax_z.s1 << 1);
                rnd_q    <= u_q;
            end
        end
    end

    assign z0      = z_q.s0;
    assign z1      = z_q.s1;
    assign rnd_out = rnd_q;
    assign done    = (state == ST_DONE);
endmodule

// File: rtl/mk_adder_chk.sv
module mk_adder_chk
    import mk_adder_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [WIDTH-1:0] x0,
    input logic [WIDTH-1:0] x1,
    input logic [WIDTH-1:0] y0,
    input logic [WIDTH-1:0] y1,
    input logic [WIDTH-1:0] z0,
    input logic [WIDTH-1:0] z1,
    input logic             rnd_out,
    input logic             done
);
    localparam int LAT = level_count(WIDTH) + 2;
    localparam int CW  = $clog2(LAT + 2) + 1;

    logic             busy_c;
    logic [CW-1:0]    cnt;
    logic [WIDTH-1:0] xs, ys, sum_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_c <= 1'b0;
            cnt    <= '0;
            xs     <= '0;
            ys     <= '0;
        end else if (!busy_c && start) begin
            busy_c <= 1'b1;
            cnt    <= CW'(1);
            xs     <= x0 ^ x1;
            ys     <= y0 ^ y1;
        end else if (busy_c) begin
            if (done) busy_c <= 1'b0;
            else      cnt    <= cnt + CW'(1);
        end
    end

    assign sum_w = xs + ys;

    assert_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> (!done && z0 == '0 && z1 == '0 && !rnd_out));

    assert_sum_R2: assert property (@(posedge clk) disable iff (rst)
        done |-> ((z0 ^ z1) == sum_w));

    assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> (busy_c && cnt == CW'(LAT)));

    assert_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R4: a start during a run never produces a done outside the latency window
    assert_no_stray_done_R4: assert property (@(posedge clk) disable iff (rst)
        !busy_c |-> !done);

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(z0) && $stable(z1) && $stable(rnd_out)));
endmodule

bind mk_adder mk_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .x0      (x0),
    .x1      (x1),
    .y0      (y0),
    .y1      (y1),
    .z0      (z0),
    .z1      (z1),
    .rnd_out (rnd_out),
    .done    (done)
);

// File: tb/sim_mk_adder.sv
`timescale 1ns/1ps
module sim_mk_adder;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    // 32-bit instance
    logic        a_start = 1'b0, a_rnd = 1'b0;
    logic [31:0] a_x0 = '0, a_x1 = '0, a_y0 = '0, a_y1 = '0;
    logic [31:0] a_z0, a_z1;
    logic        a_rout, a_done;
    // 8-bit instance
    logic        b_start = 1'b0, b_rnd = 1'b0;
    logic [7:0]  b_x0 = '0, b_x1 = '0, b_y0 = '0, b_y1 = '0;
    logic [7:0]  b_z0, b_z1;
    logic        b_rout, b_done;

    mk_adder #(.WIDTH(32)) u0 (
        .clk(clk), .rst(rst), .start(a_start),
        .x0(a_x0), .x1(a_x1), .y0(a_y0), .y1(a_y1), .rnd_in(a_rnd),
        .z0(a_z0), .z1(a_z1), .rnd_out(a_rout), .done(a_done));

    mk_adder #(.WIDTH(8)) u1 (
        .clk(clk), .rst(rst), .start(b_start),
        .x0(b_x0), .x1(b_x1), .y0(b_y0), .y1(b_y1), .rnd_in(b_rnd),
        .z0(b_z0), .z1(b_z1), .rnd_out(b_rout), .done(b_done));

    int n_chk = 0;
    int n_fail = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    typedef struct packed {
        logic [31:0] x;
        logic [31:0] y;
        logic [31:0] mx;
        logic [31:0] my;
        logic [31:0] sum;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{32'h0000_0000, 32'h0000_0000, 32'h1357_9BDF, 32'h2468_ACE0, 32'h0000_0000},
        '{32'hFFFF_FFFF, 32'h0000_0001, 32'hA5A5_5A5A, 32'h0F0F_F0F0, 32'h0000_0000},
        '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h8000_0001, 32'h7FFF_FFFE, 32'hFFFF_FFFE},
        '{32'h7FFF_FFFF, 32'h0000_0001, 32'hC001_D00D, 32'h0BAD_F00D, 32'h8000_0000},
        '{32'h1234_5678, 32'h9ABC_DEF0, 32'h5555_AAAA, 32'h3333_CCCC, 32'hACF1_3568},
        '{32'h8000_0000, 32'h8000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000},
        '{32'hAAAA_AAAA, 32'h5555_5556, 32'h6B6B_6B6B, 32'h9E9E_9E9E, 32'h0000_0000},
        '{32'hDEAD_BEEF, 32'h0000_0001, 32'h0123_4567, 32'h89AB_CDEF, 32'hDEAD_BEF0}
    };

    // Drive one 32-bit addition; return sum of output shares and cycles to done.
    task automatic run32(input logic [31:0] x, y, mx, my, input logic r,
                         output logic [31:0] zs, output int lat);
        @(negedge clk);
        a_x0 = x ^ mx; a_x1 = mx; a_y0 = y ^ my; a_y1 = my; a_rnd = r;
        a_start = 1'b1;
        @(negedge clk);
        a_start = 1'b0;
        lat = 1;
        while (!a_done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        zs = a_z0 ^ a_z1;
    endtask

    task automatic run8(input logic [7:0] x, y, mx, my, input logic r,
                        output logic [7:0] zs, output logic ro, output int lat);
        @(negedge clk);
        b_x0 = x ^ mx; b_x1 = mx; b_y0 = y ^ my; b_y1 = my; b_rnd = r;
        b_start = 1'b1;
        @(negedge clk);
        b_start = 1'b0;
        lat = 1;
        while (!b_done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        zs = b_z0 ^ b_z1;
        ro = b_rout;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] zs, sz0, sz1;
        logic [7:0]  zb;
        logic        ro, sro;
        int          lat;
        int          extra;

        repeat (3) @(negedge clk);
        // R1: outputs while reset is held
        check("R1 done32 in reset", {31'b0, a_done}, 32'h0);
        check("R1 z0 32 in reset", a_z0, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 z1 32 after reset", a_z1, 32'h0);
        check("R1 rnd_out32 after reset", {31'b0, a_rout}, 32'h0);
        check("R1 done8/z8 after reset", {15'b0, b_done, b_z0, b_z1}, 32'h0);

        // R2/R3: fixed vector table on the 32-bit unit
        for (int i = 0; i < 8; i++) begin
            run32(VECS[i].x, VECS[i].y, VECS[i].mx, VECS[i].my, i[0], zs, lat);
            check($sformatf("R2 table[%0d]", i), zs, VECS[i].sum);
            check($sformatf("R3 latency table[%0d]", i), lat, 32'd7);
            @(negedge clk);
            check("R3 done single pulse", {31'b0, a_done}, 32'h0);
        end

        // R2: random operands and share splits, 32 bit
        for (int i = 0; i < 150; i++) begin
            logic [31:0] rx, ry;
            rx = $urandom; ry = $urandom;
            if (i % 10 == 0) ry = ~rx;           // sums to all-ones
            if (i % 10 == 1) ry = (~rx) + 32'd1; // full-length carry to zero
            run32(rx, ry, $urandom, $urandom, 1'($urandom), zs, lat);
            check("R2 random32", zs, rx + ry);
        end

        // 8-bit unit: corner values, random values, guard bit handed back
        begin
            logic [7:0] cx [6] = '{8'hFF, 8'hFF, 8'h80, 8'h7F, 8'h55, 8'h00};
            logic [7:0] cy [6] = '{8'hFF, 8'h01, 8'h80, 8'h01, 8'hAB, 8'h00};
            for (int i = 0; i < 6; i++) begin
                logic [7:0] mx, my;
                mx = 8'($urandom); my = 8'($urandom);
                run8(cx[i], cy[i], mx, my, 1'($urandom), zb, ro, lat);
                check("R2 corner8", {24'b0, zb}, {24'b0, 8'(cx[i] + cy[i])});
                check("R3 latency8", lat, 32'd5);
                check("R6 guard bit8", {31'b0, ro},
                      {31'b0, ((cx[i] ^ mx) ^ (cy[i] ^ my)) >> 1 & 8'h01 ? 1'b1 : 1'b0});
            end
        end
        for (int i = 0; i < 150; i++) begin
            logic [7:0] rx, ry, mx, my;
            rx = 8'($urandom); ry = 8'($urandom);
            mx = 8'($urandom); my = 8'($urandom);
            run8(rx, ry, mx, my, 1'($urandom), zb, ro, lat);
            check("R2 random8", {24'b0, zb}, {24'b0, 8'(rx + ry)});
            check("R6 random guard8", {31'b0, ro}, {31'b0, ((rx ^ mx) ^ (ry ^ my)) >> 1 & 8'h01 ? 1'b1 : 1'b0});
        end

        // R4: second start while running is ignored
        @(negedge clk);
        a_x0 = 32'h0000_1111 ^ 32'h7777_0000; a_x1 = 32'h7777_0000;
        a_y0 = 32'h0000_2222; a_y1 = 32'h0;
        a_start = 1'b1;
        @(negedge clk);
        a_start = 1'b0;
        lat = 1;
        @(negedge clk); lat++;
        a_x0 = 32'hFFFF_0000; a_x1 = 32'h0; a_y0 = 32'h0F0F_0000; a_y1 = 32'h0;
        a_start = 1'b1;
        @(negedge clk); lat++;
        a_start = 1'b0;
        while (!a_done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        check("R4 busy start ignored latency", lat, 32'd7);
        check("R4 busy start ignored sum", a_z0 ^ a_z1, 32'h0000_3333);
        // start during done cycle is also ignored
        a_start = 1'b1;
        @(negedge clk);
        a_start = 1'b0;
        extra = 0;
        for (int c = 0; c < 12; c++) begin
            if (a_done) extra++;
            @(negedge clk);
        end
        check("R4 no done after ignored starts", extra, 32'd0);

        // R5: outputs hold while inputs move without start
        run32(32'hCAFE_0001, 32'h0000_FFFF, 32'h1111_1111, 32'h2222_2222, 1'b1, zs, lat);
        sz0 = a_z0; sz1 = a_z1; sro = a_rout;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            a_x0 = $urandom; a_y1 = $urandom; a_rnd = ~a_rnd;
        end
        check("R5 hold z0", a_z0, sz0);
        check("R5 hold z1", a_z1, sz1);
        check("R5 hold rnd_out", {31'b0, a_rout}, {31'b0, sro});

        summary();
        $finish;
    end
endmodule